// File: doc/BRIEF.md
# Programmable Raster Timing Engine

This block generates the raster timing for a display output. It treats a whole frame as one linear run of pixel clocks: a frame-position counter runs from zero to the frame length minus one, and a line-position counter runs alongside it. All vertical limits are absolute positions inside that frame-long count, so software computes them as line counts multiplied by the line length. From these two counters the block derives horizontal sync, vertical sync and data enable, each with its own inversion bit. It also drives a pixel output that carries input pixels inside the active area, a border colour in the part of the display area that lies outside an optionally narrowed active window, and an underflow colour whenever the pixel source has nothing valid while the active area is being scanned.

A small word-addressed register port programs the engine. Writing any nonzero value to address 0 starts it. A one-clock fetch trigger can be placed at any frame position. Frame and line counters can be read back. Timing registers written while the engine runs take effect only at the next frame start, so a frame in progress is never torn.

Top module: `vtg_core`

## Requirements
- R1: After reset, hsync, vsync, de, pix_take and fetch_start_p are low, pix_out is zero, and the frame-count (address 17) and line-count (address 18) registers read zero.
- R2: Registers read back the last value written: address 2 line control, 7 display horizontal window, 11 border colour, 13 skew. Writes to the read-only count addresses 17 and 18 are ignored. Writing any nonzero value to address 0 starts the engine, writing zero stops it.
- R3: Address 2 holds the line length in bits 31:16 and the hsync width in bits 15:0; hsync is active during the first hsync-width clocks of every line.
- R4: Address 3 holds the frame length in clocks; the frame position wraps to zero after it. Address 4 holds the vsync width in clocks; vsync is active while the frame position is below it.
- R5: The display window is frame positions from address 5 to address 6 inclusive and line positions from bits 15:0 to bits 31:16 of address 7 inclusive. With no active window enabled, de is high and pix_out carries pix_in there; outside it de is low and pix_out is zero.
- R6: Config (address 1) bit 29 limits the active area to line positions from bits 15:0 to bits 31:16 of address 8; bit 30 limits it to frame positions from address 9 to address 10. Inside the display window but outside the active area, pix_out carries the border colour with de and pix_take low.
- R7: Inside the active area, pix_take is high; if pix_valid is low, pix_out carries the underflow colour (address 12).
- R8: Address 14 bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de.
- R9: With config bit 31 set, fetch_start_p pulses for one clock when the frame position equals address 16.
- R10: Address 15 bit 0 enables frame counting (one per frame wrap) and bit 1 enables line counting (one per line wrap, cleared at frame wrap).
- R11: Timing registers (addresses 2 to 10) written while running take effect from the first clock of the next frame.
- R12: When stopped, frame position, frame count and line count return to zero and the sync and enable outputs rest at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pix_in | input | PIX_W | Pixel from the source |
| pix_valid | input | 1 | pix_in holds a valid pixel |
| pix_take | output | 1 | A pixel is consumed this clock |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_out | output | PIX_W | Pixel, border or underflow colour |
| fetch_start_p | output | 1 | One-clock fetch trigger |

## Verification
The bench builds the block with its default 24-bit pixel width and programs a 10-clock line in a 60-clock frame of six lines. That small raster puts every edge of the sync, display and active windows, the fetch position and several frame wraps within a few hundred clocks, so the shadow update at a frame boundary and the count registers after whole and partial frames can be checked against an independent position model in full.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 5;
  localparam int HPOS_W = REG_W / 2;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_ENABLE   = 5'd0;
  localparam addr_t A_CONFIG   = 5'd1;
  localparam addr_t A_LINE     = 5'd2;
  localparam addr_t A_FLEN     = 5'd3;
  localparam addr_t A_VSW      = 5'd4;
  localparam addr_t A_DV_BEG   = 5'd5;
  localparam addr_t A_DV_LAST  = 5'd6;
  localparam addr_t A_DH       = 5'd7;
  localparam addr_t A_AH       = 5'd8;
  localparam addr_t A_AV_BEG   = 5'd9;
  localparam addr_t A_AV_LAST  = 5'd10;
  localparam addr_t A_BORDER   = 5'd11;
  localparam addr_t A_UNDER    = 5'd12;
  localparam addr_t A_SKEW     = 5'd13;
  localparam addr_t A_POL      = 5'd14;
  localparam addr_t A_CNT_EN   = 5'd15;
  localparam addr_t A_FETCH_AT = 5'd16;
  localparam addr_t A_FCOUNT   = 5'd17;
  localparam addr_t A_LCOUNT   = 5'd18;

  // config bits kept by the engine: {fetch, active-v, active-h}
  localparam int CFG_LSB = 29;
  localparam int CFG_W   = 3;

  typedef struct packed {
    logic [REG_W-1:0] line;
    logic [REG_W-1:0] flen;
    logic [REG_W-1:0] vsw;
    logic [REG_W-1:0] dv_beg;
    logic [REG_W-1:0] dv_last;
    logic [REG_W-1:0] dh;
    logic [REG_W-1:0] ah;
    logic [REG_W-1:0] av_beg;
    logic [REG_W-1:0] av_last;
  } timing_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  addr_t             addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [REG_W-1:0]  frame_cnt,
  input  logic [HPOS_W-1:0] line_cnt,
  input  logic              frame_end,
  output logic              run,
  output logic [CFG_W-1:0]  cfg,
  output logic [2:0]        pol,
  output logic [PIX_W-1:0]  border,
  output logic [PIX_W-1:0]  under,
  output logic [REG_W-1:0]  fetch_at,
  output logic [1:0]        cnt_en,
  output timing_t           tim
);
  logic              en_q,     en_n;
  logic [CFG_W-1:0]  cfg_q,    cfg_n;
  logic [2:0]        pol_q,    pol_n;
  logic [PIX_W-1:0]  border_q, border_n;
  logic [PIX_W-1:0]  under_q,  under_n;
  logic [REG_W-1:0]  skew_q,   skew_n;
  logic [1:0]        cnten_q,  cnten_n;
  logic [REG_W-1:0]  fetch_q,  fetch_n;
  timing_t           prog_q,   prog_n;
  timing_t           tim_q;
  logic              shadow_ld;

  // next state for the programmed copies
  always_comb begin
    en_n     = en_q;
    cfg_n    = cfg_q;
    pol_n    = pol_q;
    border_n = border_q;
    under_n  = under_q;
    skew_n   = skew_q;
    cnten_n  = cnten_q;
    fetch_n  = fetch_q;
    prog_n   = prog_q;
    if (wr) begin
      unique case (addr)
        A_ENABLE:   en_n           = |wdata;
        A_CONFIG:   cfg_n          = wdata[CFG_LSB +: CFG_W];
        A_LINE:     prog_n.line    = wdata;
        A_FLEN:     prog_n.flen    = wdata;
        A_VSW:      prog_n.vsw     = wdata;
        A_DV_BEG:   prog_n.dv_beg  = wdata;
        A_DV_LAST:  prog_n.dv_last = wdata;
        A_DH:       prog_n.dh      = wdata;
        A_AH:       prog_n.ah      = wdata;
        A_AV_BEG:   prog_n.av_beg  = wdata;
        A_AV_LAST:  prog_n.av_last = wdata;
        A_BORDER:   border_n       = wdata[PIX_W-1:0];
        A_UNDER:    under_n        = wdata[PIX_W-1:0];
        A_SKEW:     skew_n         = wdata;
        A_POL:      pol_n          = wdata[2:0];
        A_CNT_EN:   cnten_n        = wdata[1:0];
        A_FETCH_AT: fetch_n        = wdata;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      cfg_q    <= '0;
      pol_q    <= '0;
      border_q <= '0;
      under_q  <= '0;
      skew_q   <= '0;
      cnten_q  <= '0;
      fetch_q  <= '0;
      prog_q   <= '0;
    end else begin
      en_q     <= en_n;
      cfg_q    <= cfg_n;
      pol_q    <= pol_n;
      border_q <= border_n;
      under_q  <= under_n;
      skew_q   <= skew_n;
      cnten_q  <= cnten_n;
      fetch_q  <= fetch_n;
      prog_q   <= prog_n;
    end
  end

  // working timing copy: follows the programmed copy while stopped,
  // and is refreshed only on the last clock of a frame while running
  assign shadow_ld = !en_q || frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tim_q <= '0;
    else if (shadow_ld) tim_q <= prog_q;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_ENABLE:   rdata = {{(REG_W-1){1'b0}}, en_q};
      A_CONFIG:   rdata[CFG_LSB +: CFG_W] = cfg_q;
      A_LINE:     rdata = prog_q.line;
      A_FLEN:     rdata = prog_q.flen;
      A_VSW:      rdata = prog_q.vsw;
      A_DV_BEG:   rdata = prog_q.dv_beg;
      A_DV_LAST:  rdata = prog_q.dv_last;
      A_DH:       rdata = prog_q.dh;
      A_AH:       rdata = prog_q.ah;
      A_AV_BEG:   rdata = prog_q.av_beg;
      A_AV_LAST:  rdata = prog_q.av_last;
      A_BORDER:   rdata[PIX_W-1:0] = border_q;
      A_UNDER:    rdata[PIX_W-1:0] = under_q;
      A_SKEW:     rdata = skew_q;
      A_POL:      rdata[2:0] = pol_q;
      A_CNT_EN:   rdata[1:0] = cnten_q;
      A_FETCH_AT: rdata = fetch_q;
      A_FCOUNT:   rdata = frame_cnt;
      A_LCOUNT:   rdata[HPOS_W-1:0] = line_cnt;
      default:    ;
    endcase
  end

  assign run      = en_q;
  assign cfg      = cfg_q;
  assign pol      = pol_q;
  assign border   = border_q;
  assign under    = under_q;
  assign fetch_at = fetch_q;
  assign cnt_en   = cnten_q;
  assign tim      = tim_q;
endmodule

// File: rtl/vtg_counters.sv
module vtg_counters
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HPOS_W-1:0] line_len,
  input  logic [REG_W-1:0]  frame_len,
  input  logic [1:0]        cnt_en,
  output logic [HPOS_W-1:0] h_pos,
  output logic [REG_W-1:0]  f_pos,
  output logic [REG_W-1:0]  frame_cnt,
  output logic [HPOS_W-1:0] line_cnt,
  output logic              frame_end
);
  logic [HPOS_W-1:0] h_q, h_n;
  logic [REG_W-1:0]  f_q, f_n;
  logic [REG_W-1:0]  fc_q, fc_n;
  logic [HPOS_W-1:0] lc_q, lc_n;
  logic              line_end;

  assign frame_end = run && (f_q == frame_len - 1'b1);
  assign line_end  = run && (h_q == line_len - 1'b1);

  always_comb begin
    h_n  = '0;
    f_n  = '0;
    fc_n = '0;
    lc_n = '0;
    if (run) begin
      f_n  = frame_end ? '0 : f_q + 1'b1;
      h_n  = (frame_end || line_end) ? '0 : h_q + 1'b1;
      fc_n = (frame_end && cnt_en[0]) ? fc_q + 1'b1 : fc_q;
      if (frame_end)                    lc_n = '0;
      else if (line_end && cnt_en[1])   lc_n = lc_q + 1'b1;
      else                              lc_n = lc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q  <= '0;
      f_q  <= '0;
      fc_q <= '0;
      lc_q <= '0;
    end else begin
      h_q  <= h_n;
      f_q  <= f_n;
      fc_q <= fc_n;
      lc_q <= lc_n;
    end
  end

  assign h_pos     = h_q;
  assign f_pos     = f_q;
  assign frame_cnt = fc_q;
  assign line_cnt  = lc_q;
endmodule

// File: rtl/vtg_window.sv
module vtg_window
  import vtg_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic              run,
  input  timing_t           tim,
  input  logic [CFG_W-1:0]  cfg,
  input  logic [2:0]        pol,
  input  logic [PIX_W-1:0]  border,
  input  logic [PIX_W-1:0]  under,
  input  logic [REG_W-1:0]  fetch_at,
  input  logic [HPOS_W-1:0] h_pos,
  input  logic [REG_W-1:0]  f_pos,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              pix_valid,
  output logic              pix_take,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [PIX_W-1:0]  pix_out,
  output logic              fetch_p
);
  logic hs_act, vs_act, in_disp, ah_ok, av_ok, in_act;
  logic [HPOS_W-1:0] hs_w, dh_beg, dh_last, ah_beg, ah_last;

  assign hs_w    = tim.line[HPOS_W-1:0];
  assign dh_beg  = tim.dh[HPOS_W-1:0];
  assign dh_last = tim.dh[REG_W-1:HPOS_W];
  assign ah_beg  = tim.ah[HPOS_W-1:0];
  assign ah_last = tim.ah[REG_W-1:HPOS_W];

  always_comb begin
    hs_act  = run && (h_pos < hs_w);
    vs_act  = run && (f_pos < tim.vsw);
    in_disp = run && (f_pos >= tim.dv_beg) && (f_pos <= tim.dv_last)
                  && (h_pos >= dh_beg) && (h_pos <= dh_last);
    ah_ok   = !cfg[0] || ((h_pos >= ah_beg) && (h_pos <= ah_last));
    av_ok   = !cfg[1] || ((f_pos >= tim.av_beg) && (f_pos <= tim.av_last));
    in_act  = in_disp && ah_ok && av_ok;
    if (in_act)       pix_out = pix_valid ? pix_in : under;
    else if (in_disp) pix_out = border;
    else              pix_out = '0;
  end

  assign pix_take = in_act;
  assign hsync    = hs_act ^ pol[0];
  assign vsync    = vs_act ^ pol[1];
  assign de       = in_act ^ pol[2];
  assign fetch_p  = run && cfg[2] && (f_pos == fetch_at);
endmodule

// File: rtl/vtg_core.sv
module vtg_core
  import vtg_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              pix_valid,
  output logic              pix_take,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [PIX_W-1:0]  pix_out,
  output logic              fetch_start_p
);
  logic              run;
  logic [CFG_W-1:0]  cfg;
  logic [2:0]        pol;
  logic [PIX_W-1:0]  border_color, under_color;
  logic [REG_W-1:0]  fetch_at;
  logic [1:0]        cnt_en;
  timing_t           tim_act;
  logic [HPOS_W-1:0] h_pos, line_cnt;
  logic [REG_W-1:0]  f_pos, frame_cnt;
  logic              frame_end;

  vtg_regs #(.PIX_W(PIX_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .frame_cnt(frame_cnt),
    .line_cnt(line_cnt), .frame_end(frame_end), .run(run), .cfg(cfg),
    .pol(pol), .border(border_color), .under(under_color),
    .fetch_at(fetch_at), .cnt_en(cnt_en), .tim(tim_act)
  );

  vtg_counters cnt_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .line_len(tim_act.line[REG_W-1:HPOS_W]), .frame_len(tim_act.flen),
    .cnt_en(cnt_en), .h_pos(h_pos), .f_pos(f_pos),
    .frame_cnt(frame_cnt), .line_cnt(line_cnt), .frame_end(frame_end)
  );

  vtg_window #(.PIX_W(PIX_W)) win_i (
    .run(run), .tim(tim_act), .cfg(cfg), .pol(pol),
    .border(border_color), .under(under_color), .fetch_at(fetch_at),
    .h_pos(h_pos), .f_pos(f_pos), .pix_in(pix_in), .pix_valid(pix_valid),
    .pix_take(pix_take), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_out(pix_out), .fetch_p(fetch_start_p)
  );
endmodule

// File: rtl/vtg_core_chk.sv
module vtg_core_chk
  import vtg_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [HPOS_W-1:0] h_pos,
  input logic [REG_W-1:0]  f_pos,
  input logic [HPOS_W-1:0] line_len,
  input logic [REG_W-1:0]  frame_len,
  input logic [REG_W-1:0]  frame_cnt,
  input logic [HPOS_W-1:0] line_cnt,
  input logic              pix_take,
  input logic              pix_valid,
  input logic [PIX_W-1:0]  pix_out,
  input logic [PIX_W-1:0]  under_color,
  input logic              fetch_p
);
  p_idle_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> (f_pos == '0 && h_pos == '0 && frame_cnt == '0 && line_cnt == '0));

  p_line_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && line_len != '0) |-> (h_pos < line_len));

  p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && frame_len != '0 && f_pos == frame_len - 1'b1) |=> (f_pos == '0));

  p_take_running_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_take |-> run);

  p_underflow_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_take && !pix_valid) |-> (pix_out == under_color));

  p_fetch_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_p |-> run);
endmodule

bind vtg_core vtg_core_chk #(.PIX_W(PIX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .h_pos(h_pos), .f_pos(f_pos),
  .line_len(tim_act.line[31:16]), .frame_len(tim_act.flen),
  .frame_cnt(frame_cnt), .line_cnt(line_cnt), .pix_take(pix_take),
  .pix_valid(pix_valid), .pix_out(pix_out), .under_color(under_color),
  .fetch_p(fetch_start_p)
);

// File: tb/vtg_core_tb_top.sv
`timescale 1ns/1ps
module vtg_core_tb_top;
  localparam int PW = 24;

  logic          clk, rst_n;
  logic          reg_wr;
  logic [4:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic [PW-1:0] pix_in, pix_out;
  logic          pix_valid, pix_take, hsync, vsync, de, fetch_start_p;

  vtg_core #(.PIX_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_in(pix_in),
    .pix_valid(pix_valid), .pix_take(pix_take), .hsync(hsync),
    .vsync(vsync), .de(de), .pix_out(pix_out), .fetch_start_p(fetch_start_p)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic          hs, vs, de, take, fetch;
    logic [PW-1:0] pix;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  // bench model of the programmed raster
  int lp, hsw, fl, vsw, dvb, dvl, dhb, dhl, ahb, ahl, avb, avl, fat;
  bit c_ah, c_av, c_fe;
  int pol;
  logic [PW-1:0] brd, ufc;
  int pend_hsw, pend_vsw;
  int m_pos;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] expv, string req);
    reg_addr = a;
    #1;
    check(reg_rdata == expv, req, $sformatf("read addr %0d", a), reg_rdata, expv);
  endtask

  // driver: sets inputs for the current clock, pushes the expectation,
  // optionally issues one register write at iteration wk
  task automatic drive(int n, bit toggle_valid, int wk, logic [4:0] wa,
                       logic [31:0] wd, string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int p, h;
      bit disp, act;
      pix_in    = PW'(i * 37 + 5);
      pix_valid = toggle_valid ? ((m_pos % 3) != 0) : 1'b1;
      if (i == wk) begin
        reg_wr = 1'b1; reg_addr = wa; reg_wdata = wd;
        if (wa == 5'd2) pend_hsw = int'(wd[15:0]);
        if (wa == 5'd4) pend_vsw = int'(wd);
      end else begin
        reg_wr = 1'b0;
      end
      p    = m_pos % fl;
      h    = p % lp;
      disp = (p >= dvb) && (p <= dvl) && (h >= dhb) && (h <= dhl);
      act  = disp && (!c_ah || (h >= ahb && h <= ahl)) && (!c_av || (p >= avb && p <= avl));
      e.hs    = (h < hsw) ^ pol[0];
      e.vs    = (p < vsw) ^ pol[1];
      e.de    = act ^ pol[2];
      e.take  = act;
      e.fetch = c_fe && (p == fat);
      e.pix   = act ? (pix_valid ? pix_in : ufc) : (disp ? brd : '0);
      e.tag   = tag;
      q.push_back(e);
      @(negedge clk);
      m_pos++;
      if ((m_pos % fl) == 0) begin
        if (pend_hsw >= 0) begin hsw = pend_hsw; pend_hsw = -1; end
        if (pend_vsw >= 0) begin vsw = pend_vsw; pend_vsw = -1; end
      end
    end
    reg_wr = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(hsync == e.hs, {e.tag, " R3"}, "hsync", hsync, e.hs);
      check(vsync == e.vs, {e.tag, " R4"}, "vsync", vsync, e.vs);
      check(de == e.de, {e.tag, " R5"}, "de", de, e.de);
      check(pix_take == e.take, {e.tag, " R6"}, "pix_take", pix_take, e.take);
      check(pix_out == e.pix, {e.tag, " R7"}, "pix_out", pix_out, e.pix);
      check(fetch_start_p == e.fetch, {e.tag, " R9"}, "fetch", fetch_start_p, e.fetch);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    reg_wr = 0; reg_addr = 0; reg_wdata = 0; pix_in = 0; pix_valid = 0;
    pend_hsw = -1; pend_vsw = -1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    #1;
    check(hsync == 0 && vsync == 0 && de == 0, "R1", "syncs", {hsync, vsync, de}, 0);
    check(pix_out == 0 && pix_take == 0 && fetch_start_p == 0, "R1", "pixel", pix_out, 0);
    rd(5'd17, 0, "R1");
    rd(5'd18, 0, "R1");

    // program a 10-clock line, 6-line frame
    lp = 10; hsw = 2; fl = 60; vsw = 10; dvb = 20; dvl = 49; dhb = 4; dhl = 7;
    ahb = 5; ahl = 6; avb = 30; avl = 39; fat = 55;
    c_ah = 0; c_av = 0; c_fe = 0; pol = 0;
    brd = 24'h123456; ufc = 24'hABCDEF;
    wr(5'd2, (32'd10 << 16) | 32'd2);
    wr(5'd3, 60); wr(5'd4, 10); wr(5'd5, 20); wr(5'd6, 49);
    wr(5'd7, (32'd7 << 16) | 32'd4);
    wr(5'd8, (32'd6 << 16) | 32'd5);
    wr(5'd9, 30); wr(5'd10, 39);
    wr(5'd11, 32'h123456); wr(5'd12, 32'hABCDEF);
    wr(5'd13, 32'h0000_0007); wr(5'd14, 0); wr(5'd15, 3); wr(5'd16, 55);
    wr(5'd1, 0);
    wr(5'd18, 32'h55);
    wr(5'd17, 32'h66);
    // R2 readback
    rd(5'd2, (32'd10 << 16) | 32'd2, "R2");
    rd(5'd7, (32'd7 << 16) | 32'd4, "R2");
    rd(5'd11, 32'h123456, "R2");
    rd(5'd13, 32'h7, "R2");
    rd(5'd18, 0, "R2");
    rd(5'd17, 0, "R2");

    // plain display window, two frames plus a partial one
    wr(5'd0, 32'h1);
    m_pos = 0;
    drive(120, 0, -1, 0, 0, "R5");
    rd(5'd17, 2, "R10");
    rd(5'd18, 0, "R10");
    drive(25, 0, -1, 0, 0, "R5");
    rd(5'd17, 2, "R10");
    rd(5'd18, 2, "R10");

    // stop: everything clears
    wr(5'd0, 0);
    @(negedge clk);
    #1;
    check(hsync == 0 && vsync == 0 && de == 0 && pix_take == 0, "R12", "idle syncs",
          {hsync, vsync, de, pix_take}, 0);
    rd(5'd17, 0, "R12");
    rd(5'd18, 0, "R12");
    rd(5'd0, 0, "R2");

    // active window, polarity, fetch, underflow, frame-only counting
    wr(5'd1, 32'hE000_0000);
    wr(5'd14, 7);
    wr(5'd15, 1);
    c_ah = 1; c_av = 1; c_fe = 1; pol = 7;
    @(negedge clk);
    #1;
    check(hsync == 1 && vsync == 1 && de == 1, "R8", "inactive inverted",
          {hsync, vsync, de}, 3'b111);
    wr(5'd0, 32'h100);
    m_pos = 0;
    drive(120, 1, -1, 0, 0, "R6 R8");
    rd(5'd17, 2, "R10");
    rd(5'd18, 0, "R10");

    // shadow update of timing while running
    drive(90, 1, 10, 5'd2, (32'd10 << 16) | 32'd3, "R11");
    rd(5'd2, (32'd10 << 16) | 32'd3, "R11");
    drive(70, 0, 5, 5'd4, 32'd20, "R11");

    #5;
    summary();
    $finish;
  end
endmodule